// File: doc/BRIEF.md
# Memory-mapped UART register front-end

This block is the register front-end of a simple UART. It connects to an APB-style slave port and offers four registers: data, status, control and scaler. A byte-wide receive stream, already deserialised upstream, feeds a parameterised receive FIFO. Software drains the FIFO by reading the data register. A write to the data register hands one byte to a byte-wide transmit stream.

The control register sets whether bytes are received or sent, and whether each kind of event raises an interrupt. The status register reports receive occupancy and a sticky overrun flag. The transmitter has no buffering, so it always reports empty.

Register accesses take effect in the APB access phase. The block never inserts wait states. Byte-wide bus masters can reach the data register at offset 3 as well as at offset 0.

Top module: `apb_uart_regs`

## Requirements
- R1: After reset the control register reads 0, the receive FIFO is empty, and status (offset 0x04) reads 0x0000_0006: bit1 (transmit shift empty) and bit2 (transmit FIFO empty) set, all other bits clear.
- R2: The control register at offset 0x08 stores all 32 bits written to it and reads them back unchanged.
- R3: A byte on rx_data_i with rx_valid_i high is pushed into the FIFO only while control bit0 (receive enable) is set. Status bit0 (data ready) is 1 exactly while the FIFO is not empty.
- R4: A read of the data register returns the oldest byte in bits 7:0, with zeros above, and removes that byte. A read with the FIFO empty returns 0 and changes nothing.
- R5: A byte that arrives while receive is enabled and the FIFO holds DEPTH bytes is dropped, and status bit4 (overrun) is set. Bit4 stays set until reset. Fullness is judged before any pop in the same cycle.
- R6: Status bit8 is 1 while the FIFO holds at least DEPTH/2 bytes. Status bit10 is 1 while it holds DEPTH bytes.
- R7: A write to the data register while control bit1 (transmit enable) is set drives tx_valid_o high for exactly the next cycle, with tx_data_o equal to pwdata_i[7:0]. With bit1 clear, no byte is sent.
- R8: irq_o is high for one cycle after each cycle in which a received byte was accepted with control bit2 set, or a byte was sent with control bit3 set. It is low otherwise.
- R9: Offset 0x03 behaves exactly like offset 0x00 for both reads and writes.
- R10: Writes to status (0x04), to scaler (0x0C) and to unmapped offsets change nothing. Scaler and unmapped offsets read as 0.
- R11: pready_o is always high, so every access completes in its first access-phase cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| paddr_i | input | ADDR_W | Byte address within the register window |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid in the access phase |
| pready_o | output | 1 | Transfer ready, tied high |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | Transmit strobe, one cycle per byte |
| irq_o | output | 1 | Interrupt pulse |

## Verification
A FIFO pointer or count that drifts shows up at the next data or status read. The wrong byte or order appears in prdata_o, or bit0, bit8 or bit10 disagree with the true occupancy. A wrong enable gate or event path shows one cycle later, as an extra or missing pulse on tx_valid_o or irq_o. The bench therefore compares those two outputs on every clock. A lost overrun flag is visible at any later status read, because the flag is meant to stay set until reset.

// File: rtl/apb_uart_pkg.sv
package apb_uart_pkg;
  localparam int unsigned OFF_DATA   = 'h00;
  localparam int unsigned OFF_DATA_B = 'h03;
  localparam int unsigned OFF_STAT   = 'h04;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_SCALE  = 'h0C;

  // control bit positions
  localparam int unsigned C_RX_EN  = 0;
  localparam int unsigned C_TX_EN  = 1;
  localparam int unsigned C_RX_IE  = 2;
  localparam int unsigned C_TX_IE  = 3;

  // status bit positions
  localparam int unsigned S_DREADY = 0;
  localparam int unsigned S_TSEMPT = 1;
  localparam int unsigned S_TFEMPT = 2;
  localparam int unsigned S_OVR    = 4;
  localparam int unsigned S_RHALF  = 8;
  localparam int unsigned S_RFULL  = 10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DATA, SEL_STAT, SEL_CTRL, SEL_SCALE
  } reg_sel_e;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] data_i,
  input  logic       pop_i,
  output logic [7:0] head_o,
  output logic       empty_o,
  output logic       half_o,
  output logic       full_o,
  output logic       drop_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign half_o  = (cnt_q >= CW'(DEPTH / 2));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign head_o  = empty_o ? 8'h00 : mem_q[rd_q];

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= inc(wr_q);
      if (do_pop)  rd_q <= inc(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o);
  p_pop_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_ctrl_i,
  input  logic [31:0] wdata_i,
  input  logic        ovr_set_i,
  output logic [31:0] ctrl_o,
  output logic        ovr_o
);
  logic [31:0] ctrl_q;
  logic        ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr_ctrl_i) ctrl_q <= wdata_i;
      if (ovr_set_i) ovr_q  <= 1'b1;
    end
  end

  assign ctrl_o = ctrl_q;
  assign ovr_o  = ovr_q;

  p_ovr_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ctrl_i |=> $stable(ctrl_q));
endmodule

// File: rtl/apb_uart_regs.sv
module apb_uart_regs
  import apb_uart_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              irq_o
);
  reg_sel_e    sel;
  logic        acc, rd_data, wr_data, wr_ctrl;
  logic [31:0] ctrl, status;
  logic        ovr;
  logic [7:0]  head;
  logic        f_empty, f_half, f_full, f_drop;
  logic        rx_push, tx_send, rx_acc;
  logic [7:0]  tx_data_q;
  logic        tx_valid_q, irq_q;

  always_comb begin
    unique case (paddr_i)
      ADDR_W'(OFF_DATA), ADDR_W'(OFF_DATA_B): sel = SEL_DATA;
      ADDR_W'(OFF_STAT):                      sel = SEL_STAT;
      ADDR_W'(OFF_CTRL):                      sel = SEL_CTRL;
      ADDR_W'(OFF_SCALE):                     sel = SEL_SCALE;
      default:                                sel = SEL_NONE;
    endcase
  end

  assign acc     = psel_i && penable_i;
  assign rd_data = acc && !pwrite_i && (sel == SEL_DATA);
  assign wr_data = acc &&  pwrite_i && (sel == SEL_DATA);
  assign wr_ctrl = acc &&  pwrite_i && (sel == SEL_CTRL);
  assign rx_push = rx_valid_i && ctrl[C_RX_EN];
  assign tx_send = wr_data && ctrl[C_TX_EN];
  assign rx_acc  = rx_push && !f_full;

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_data_i),
    .pop_i   (rd_data),
    .head_o  (head),
    .empty_o (f_empty),
    .half_o  (f_half),
    .full_o  (f_full),
    .drop_o  (f_drop)
  );

  uart_ctrl_regs u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (pwdata_i),
    .ovr_set_i (f_drop),
    .ctrl_o    (ctrl),
    .ovr_o     (ovr)
  );

  always_comb begin
    status           = '0;
    status[S_DREADY] = !f_empty;
    status[S_TSEMPT] = 1'b1;
    status[S_TFEMPT] = 1'b1;
    status[S_OVR]    = ovr;
    status[S_RHALF]  = f_half;
    status[S_RFULL]  = f_full;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: prdata_o = {24'h0, head};
      SEL_STAT: prdata_o = status;
      SEL_CTRL: prdata_o = ctrl;
      default:  prdata_o = '0;
    endcase
  end

  assign pready_o = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_q  <= '0;
      tx_valid_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      tx_valid_q <= tx_send;
      if (tx_send) tx_data_q <= pwdata_i[7:0];
      irq_q <= (rx_acc && ctrl[C_RX_IE]) || (tx_send && ctrl[C_TX_IE]);
    end
  end

  assign tx_data_o  = tx_data_q;
  assign tx_valid_o = tx_valid_q;
  assign irq_o      = irq_q;

  p_tx_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && pwrite_i && !ctrl[C_TX_EN]) |=> !tx_valid_o);
  p_rx_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[C_RX_EN] && !rd_data && f_empty) |=> f_empty);
  p_irq_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[C_RX_IE:C_TX_EN] == 3'b000 && !wr_ctrl) |=> !irq_o);
  p_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> pready_o);
endmodule

// File: tb/apb_uart_regs_tb_top.sv
module apb_uart_regs_tb_top;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  paddr_i = '0;
  logic        psel_i = 1'b0, penable_i = 1'b0, pwrite_i = 1'b0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o;
  logic        pready_o;
  logic [7:0]  rx_data_i = '0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, irq_o;

  int unsigned n_chk = 0, n_fail = 0, cyc = 0;

  apb_uart_regs #(.ADDR_W(8), .DEPTH(DEPTH)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  // reference model
  logic [7:0]  mq[$];
  logic [31:0] m_ctrl;
  bit          m_ovr, m_txv, m_irq;
  logic [7:0]  m_txd;

  function automatic bit is_data(input logic [7:0] a);
    return a == 8'h00 || a == 8'h03;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mq.delete(); m_ctrl = '0; m_ovr = 0; m_txv = 0; m_irq = 0; m_txd = '0;
    end else begin
      automatic bit acc = psel_i && penable_i;
      automatic bit rxa = 0, txs = 0, popd;
      automatic int sz = mq.size();
      popd = acc && !pwrite_i && is_data(paddr_i) && sz > 0;
      txs  = acc && pwrite_i && is_data(paddr_i) && m_ctrl[1];
      if (rx_valid_i && m_ctrl[0]) begin
        if (sz < DEPTH) rxa = 1; else m_ovr = 1;
      end
      if (popd) void'(mq.pop_front());
      if (rxa) mq.push_back(rx_data_i);
      m_irq = (rxa && m_ctrl[2]) || (txs && m_ctrl[3]);
      m_txv = txs;
      if (txs) m_txd = pwdata_i[7:0];
      if (acc && pwrite_i && paddr_i == 8'h08) m_ctrl = pwdata_i;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] s = 32'h6;
    if (is_data(a)) return (mq.size() > 0) ? {24'h0, mq[0]} : 32'h0;
    if (a == 8'h04) begin
      s[0]  = mq.size() > 0;
      s[4]  = m_ovr;
      s[8]  = mq.size() >= DEPTH / 2;
      s[10] = mq.size() == DEPTH;
      return s;
    end
    if (a == 8'h08) return m_ctrl;
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of outputs (R7, R8, R11)
  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      check("R7 tx_valid", {31'h0, tx_valid_o}, {31'h0, m_txv});
      if (m_txv) check("R7 tx_data", {24'h0, tx_data_o}, {24'h0, m_txd});
      check("R8 irq", {31'h0, irq_o}, {31'h0, m_irq});
      check("R11 pready", {31'h0, pready_o}, 32'h1);
    end
  end

  task automatic apb(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                     input bit use_exp, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = wr; paddr_i = a; pwdata_i = wd;
    @(negedge clk_i);
    penable_i = 1;
    #1;
    if (!wr) begin
      check(tag, prdata_o, model_read(a));
      if (use_exp) check(tag, prdata_o, exp);
    end
    @(negedge clk_i);
    psel_i = 0; penable_i = 0;
  endtask

  task automatic rx(input logic [7:0] d);
    @(negedge clk_i);
    rx_valid_i = 1; rx_data_i = d;
    @(negedge clk_i);
    rx_valid_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    apb(0, 8'h04, 0, 1, 32'h6, "R1 status");
    apb(0, 8'h08, 0, 1, 32'h0, "R1 ctrl");
    apb(0, 8'h00, 0, 1, 32'h0, "R1 data empty");
    // R2 control read-back
    apb(1, 8'h08, 32'hA5A5_1230, 0, 0, "R2");
    apb(0, 8'h08, 0, 1, 32'hA5A5_1230, "R2 ctrl readback");
    apb(1, 8'h08, 32'h0, 0, 0, "R2");
    // R3 receive disabled ignores bytes
    rx(8'h11); rx(8'h22);
    apb(0, 8'h04, 0, 1, 32'h6, "R3 no ready when disabled");
    // R3/R4/R8 enable receive + rx irq
    apb(1, 8'h08, 32'h5, 0, 0, "R3");
    rx(8'h31); rx(8'h32); rx(8'h33);
    apb(0, 8'h04, 0, 1, 32'h7, "R3 data ready");
    apb(0, 8'h00, 0, 1, 32'h31, "R4 pop order");
    apb(0, 8'h03, 0, 1, 32'h32, "R9 byte offset read");
    apb(0, 8'h00, 0, 1, 32'h33, "R4 pop order");
    apb(0, 8'h04, 0, 1, 32'h6, "R3 ready clears");
    apb(0, 8'h00, 0, 1, 32'h0, "R4 empty read");
    apb(0, 8'h04, 0, 1, 32'h6, "R4 empty read no effect");
    // R6 fill levels, R5 overrun
    apb(1, 8'h08, 32'h1, 0, 0, "R6");
    for (int i = 0; i < DEPTH; i++) begin
      rx(8'h40 + 8'(i));
      apb(0, 8'h04, 0, 0, 0, "R6 level");
    end
    apb(0, 8'h04, 0, 1, 32'h507, "R6 half+full");
    rx(8'hEE);
    apb(0, 8'h04, 0, 1, 32'h517, "R5 overrun set");
    // pop while byte arrives at full: fullness judged pre-pop
    fork
      apb(0, 8'h00, 0, 1, 32'h40, "R5 pop at full");
      begin @(negedge clk_i); rx(8'hEF); end
    join
    for (int i = 1; i < DEPTH; i++) apb(0, 8'h00, 0, 1, 32'h40 + i, "R5 drained order");
    apb(0, 8'h04, 0, 1, 32'h16, "R5 overrun sticky");
    // simultaneous push and pop on a one-entry FIFO
    rx(8'h55);
    fork
      apb(0, 8'h00, 0, 1, 32'h55, "R4 pop with push");
      begin @(negedge clk_i); rx(8'h66); end
    join
    apb(0, 8'h00, 0, 1, 32'h66, "R4 pushed during pop");
    // R7/R8 transmit
    apb(1, 8'h08, 32'h2, 0, 0, "R7");
    apb(1, 8'h00, 32'h0000_01C3, 0, 0, "R7 send no irq");
    apb(1, 8'h08, 32'hA, 0, 0, "R8");
    apb(1, 8'h03, 32'h0000_005A, 0, 0, "R9 byte offset write irq");
    apb(1, 8'h08, 32'h8, 0, 0, "R7");
    apb(1, 8'h00, 32'h77, 0, 0, "R7 disabled no send");
    // R10 ignored writes
    apb(1, 8'h04, 32'hFFFF_FFFF, 0, 0, "R10");
    apb(1, 8'h0C, 32'h1234, 0, 0, "R10");
    apb(1, 8'h10, 32'h1234, 0, 0, "R10");
    apb(0, 8'h04, 0, 1, 32'h16, "R10 status unchanged");
    apb(0, 8'h0C, 0, 1, 32'h0, "R10 scaler zero");
    apb(0, 8'h10, 0, 1, 32'h0, "R10 unmapped zero");
    apb(0, 8'h08, 0, 1, 32'h8, "R10 ctrl unchanged");
    repeat (3) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule